// File: doc/BRIEF.md
# Halfword Multiply-Accumulate Unit

This datapath multiplies two halfword operands and either returns the product on its own or folds it into a 32-bit running value, adding or subtracting. A control bit chooses whether the operands and the running value are read as two's-complement or as unsigned numbers. A second control bit chooses between wrap-around and clamped results. The unit accepts one operation on every clock. Each result comes out of a register one cycle later, together with a valid flag and a flag that shows whether clamping changed the value.

A surrounding execute stage supplies the operands and the running value, then writes `result` back. Decode, register access and forwarding stay outside the block. The operand width is a parameter, and the result width is always twice that width.

Top module: `hmac_unit`

## Requirements
- R1: With `ctl_accum`=0 and `ctl_signed`=0, `result` is the zero-extended product `op_a*op_b`.
- R2: With `ctl_accum`=0 and `ctl_signed`=1, `result` is the sign-extended two's-complement product. `ctl_sub` and `ctl_sat` have no effect, and `ovf` is 0.
- R3: With `ctl_accum`=1, `ctl_sub`=0 and `ctl_sat`=0, `result` is the low 32 bits of `acc_in + product`.
- R4: With `ctl_accum`=1, `ctl_sub`=1 and `ctl_sat`=0, `result` is the low 32 bits of `acc_in - product`.
- R5: With `ctl_accum`=1, `ctl_sat`=1 and `ctl_signed`=1, a true result above 0x7FFFFFFF gives 0x7FFFFFFF, and a true result below -2^31 gives 0x80000000. Any other true result is returned unchanged.
- R6: With `ctl_accum`=1, `ctl_sat`=1 and `ctl_signed`=0, the operation reads `acc_in` as unsigned. A true result above 0xFFFFFFFF gives 0xFFFFFFFF, and a negative true result gives 0.
- R7: `ovf` is 1 only when clamping changed the result. It is 0 whenever `ctl_sat`=0 or `ctl_accum`=0, and 0 when a clamped-mode result lands exactly on a bound.
- R8: An operation presented with `in_valid`=1 at a clock edge appears on `result`/`ovf` after that edge with `out_valid`=1. Back-to-back operations are accepted on every cycle, and `out_valid` follows the previous cycle's `in_valid`.
- R9: A cycle with `in_valid`=0 leaves `result` and `ovf` unchanged.
- R10: While `rst` is high at a clock edge, `out_valid`, `result` and `ovf` become 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| op_a | input | OP_W (16) | First multiplier operand |
| op_b | input | OP_W (16) | Second multiplier operand |
| acc_in | input | 2*OP_W (32) | Running value to add to or subtract from |
| ctl_signed | input | 1 | 1: two's-complement operands and running value; 0: unsigned |
| ctl_accum | input | 1 | 1: accumulate; 0: product only |
| ctl_sub | input | 1 | 1: subtract product; 0: add |
| ctl_sat | input | 1 | 1: clamped arithmetic; 0: wrap-around |
| out_valid | output | 1 | Registered result is new |
| result | output | 2*OP_W (32) | Registered result |
| ovf | output | 1 | Clamping altered the registered result |

## Verification
On every cycle the assertions check the timing relations:
- `out_valid` tracks the previous `in_valid`.
- Idle cycles hold `result` and `ovf`.
- `ovf` never rises outside accumulate-with-clamp mode.
- Whenever `ovf` is set, `result` equals one of the four bounds.

Only the bench can show that the values are right. It sweeps every operand pair of a 4-bit configuration across edge-case running values and all sixteen control combinations, and compares each result with arithmetic done in wide integers. Directed 16-bit cases then cover the exact bound values and the exact-fit cases that must not raise `ovf`.

// File: rtl/hmac_pkg.sv
package hmac_pkg;

    // Control bits of one operation, carried as one value through the datapath.
    typedef struct packed {
        logic twos;    // operands and running value are two's complement
        logic accum;   // fold the product into the running value
        logic sub;     // subtract instead of add
        logic clamp;   // clamped arithmetic instead of wrap-around
    } mac_ctl_t;

    typedef enum logic [1:0] {
        CLAMP_NONE = 2'd0,
        CLAMP_HIGH = 2'd1,
        CLAMP_LOW  = 2'd2
    } clamp_e;

    // The intermediate width holds any true result of acc +/- product exactly.
    function automatic int ext_width(input int acc_w);
        return acc_w + 3;
    endfunction

endpackage

// File: rtl/hmac_mul.sv
module hmac_mul #(
    parameter int OP_W = 16,
    parameter int XW   = 2 * OP_W + 3
) (
    input  logic                 twos,
    input  logic [OP_W-1:0]      a,
    input  logic [OP_W-1:0]      b,
    output logic signed [XW-1:0] prod
);
    logic signed [XW-1:0] a_x;
    logic signed [XW-1:0] b_x;

    // Fill the upper bits with the operand's sign in two's-complement mode, with 0 otherwise.
    assign a_x  = {{(XW-OP_W){a[OP_W-1] & twos}}, a};
    assign b_x  = {{(XW-OP_W){b[OP_W-1] & twos}}, b};
    assign prod = a_x * b_x;
endmodule

// File: rtl/hmac_addsub.sv
module hmac_addsub #(
    parameter int ACC_W = 32,
    parameter int XW    = ACC_W + 3
) (
    input  hmac_pkg::mac_ctl_t   ctl,
    input  logic [ACC_W-1:0]     acc,
    input  logic signed [XW-1:0] prod,
    output logic signed [XW-1:0] total
);
    logic signed [XW-1:0] acc_x;

    assign acc_x = {{(XW-ACC_W){acc[ACC_W-1] & ctl.twos}}, acc};

    always_comb begin
        if (!ctl.accum) begin
            total = prod;
        end else if (ctl.sub) begin
            total = acc_x - prod;
        end else begin
            total = acc_x + prod;
        end
    end
endmodule

// File: rtl/hmac_sat.sv
module hmac_sat #(
    parameter int ACC_W = 32,
    parameter int XW    = ACC_W + 3
) (
    input  hmac_pkg::mac_ctl_t   ctl,
    input  logic signed [XW-1:0] total,
    output logic [ACC_W-1:0]     res,
    output logic                 ovf
);
    import hmac_pkg::*;

    localparam logic signed [XW-1:0] ONE  = XW'(1);
    localparam logic signed [XW-1:0] ZERO = '0;
    localparam logic signed [XW-1:0] S_HI = (ONE <<< (ACC_W - 1)) - ONE;
    localparam logic signed [XW-1:0] S_LO = ZERO - (ONE <<< (ACC_W - 1));
    localparam logic signed [XW-1:0] U_HI = (ONE <<< ACC_W) - ONE;

    logic signed [XW-1:0] hi_b;
    logic signed [XW-1:0] lo_b;
    clamp_e               pick;

    // Bounds for the selected number format.
    assign hi_b = ctl.twos ? S_HI : U_HI;
    assign lo_b = ctl.twos ? S_LO : ZERO;

    always_comb begin
        pick = CLAMP_NONE;
        if (ctl.clamp && ctl.accum) begin
            if (total > hi_b) begin
                pick = CLAMP_HIGH;
            end else if (total < lo_b) begin
                pick = CLAMP_LOW;
            end
        end
    end

    always_comb begin
        unique case (pick)
            CLAMP_HIGH: res = hi_b[ACC_W-1:0];
            CLAMP_LOW:  res = lo_b[ACC_W-1:0];
            default:    res = total[ACC_W-1:0];
        endcase
    end

    assign ovf = (pick != CLAMP_NONE);
endmodule

// File: rtl/hmac_unit.sv
module hmac_unit #(
    parameter int OP_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [OP_W-1:0]     op_a,
    input  logic [OP_W-1:0]     op_b,
    input  logic [2*OP_W-1:0]   acc_in,
    input  logic                ctl_signed,
    input  logic                ctl_accum,
    input  logic                ctl_sub,
    input  logic                ctl_sat,
    output logic                out_valid,
    output logic [2*OP_W-1:0]   result,
    output logic                ovf
);
    import hmac_pkg::*;

    localparam int ACC_W = 2 * OP_W;
    localparam int XW    = ext_width(ACC_W);

    localparam logic [ACC_W-1:0] V_SMAX = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic [ACC_W-1:0] V_SMIN = {1'b1, {(ACC_W-1){1'b0}}};
    localparam logic [ACC_W-1:0] V_UMAX = '1;
    localparam logic [ACC_W-1:0] V_ZERO = '0;

    mac_ctl_t             ctl;
    logic signed [XW-1:0] prod;
    logic signed [XW-1:0] total;
    logic [ACC_W-1:0]     res_d;
    logic                 ovf_d;

    assign ctl = '{twos: ctl_signed, accum: ctl_accum, sub: ctl_sub, clamp: ctl_sat};

    hmac_mul #(.OP_W(OP_W), .XW(XW)) u_mul (
        .twos (ctl.twos),
        .a    (op_a),
        .b    (op_b),
        .prod (prod)
    );

    hmac_addsub #(.ACC_W(ACC_W), .XW(XW)) u_addsub (
        .ctl   (ctl),
        .acc   (acc_in),
        .prod  (prod),
        .total (total)
    );

    hmac_sat #(.ACC_W(ACC_W), .XW(XW)) u_sat (
        .ctl   (ctl),
        .total (total),
        .res   (res_d),
        .ovf   (ovf_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result    <= '0;
            ovf       <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result <= res_d;
                ovf    <= ovf_d;
            end
        end
    end

    // R8: the valid flag follows the accept strobe with one cycle of delay
    assert_valid_follows_R8: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    assert_idle_no_valid_R8: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R9: idle cycles leave the registered result untouched
    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(result) && $stable(ovf)));

    // R7: the flag is raised only in accumulate-with-clamp mode
    assert_ovf_mode_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !(ctl_sat && ctl_accum)) |=> !ovf);

    // R5 / R6: a flagged result is always one of the bounds
    assert_ovf_at_bound_R5_R6: assert property (@(posedge clk) disable iff (rst)
        ovf |-> (result == V_SMAX || result == V_SMIN ||
                 result == V_UMAX || result == V_ZERO));
endmodule

// File: tb/hmac_unit_bench.sv
module hmac_unit_bench;
    localparam int CLK_PERIOD = 10;
    localparam int SOW = 4;
    localparam int DOW = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // small configuration (sweep)
    logic              s_iv = 0, s_sg = 0, s_ac = 0, s_sb = 0, s_st = 0;
    logic [SOW-1:0]    s_a = '0, s_b = '0;
    logic [2*SOW-1:0]  s_acc = '0;
    logic              s_ov, s_ovf;
    logic [2*SOW-1:0]  s_res;

    // default configuration (directed)
    logic              d_iv = 0, d_sg = 0, d_ac = 0, d_sb = 0, d_st = 0;
    logic [DOW-1:0]    d_a = '0, d_b = '0;
    logic [2*DOW-1:0]  d_acc = '0;
    logic              d_ov, d_ovf;
    logic [2*DOW-1:0]  d_res;

    hmac_unit #(.OP_W(SOW)) u_hmac_unit_small (
        .clk(clk), .rst(rst), .in_valid(s_iv), .op_a(s_a), .op_b(s_b), .acc_in(s_acc),
        .ctl_signed(s_sg), .ctl_accum(s_ac), .ctl_sub(s_sb), .ctl_sat(s_st),
        .out_valid(s_ov), .result(s_res), .ovf(s_ovf));

    hmac_unit u_hmac_unit (
        .clk(clk), .rst(rst), .in_valid(d_iv), .op_a(d_a), .op_b(d_b), .acc_in(d_acc),
        .ctl_signed(d_sg), .ctl_accum(d_ac), .ctl_sub(d_sb), .ctl_sat(d_st),
        .out_valid(d_ov), .result(d_res), .ovf(d_ovf));

    // Reference arithmetic in wide integers; returns {ovf, result}.
    function automatic logic [32:0] model(input int ow, input longint a, input longint b,
                                          input longint acc, input bit sg, input bit ac,
                                          input bit sb, input bit st);
        int aw = 2 * ow;
        longint mask = (64'sd1 <<< aw) - 1;
        longint av = a, bv = b, cv = acc, p, t, hi, lo;
        if (sg && ((a >>> (ow-1)) & 1) == 1) av = a - (64'sd1 <<< ow);
        if (sg && ((b >>> (ow-1)) & 1) == 1) bv = b - (64'sd1 <<< ow);
        if (sg && ((acc >>> (aw-1)) & 1) == 1) cv = acc - (64'sd1 <<< aw);
        p = av * bv;
        if (!ac) return {1'b0, 32'(p & mask)};
        t = sb ? cv - p : cv + p;
        if (st) begin
            hi = sg ? (64'sd1 <<< (aw-1)) - 1 : (64'sd1 <<< aw) - 1;
            lo = sg ? -(64'sd1 <<< (aw-1)) : 0;
            if (t > hi) return {1'b1, 32'(hi & mask)};
            if (t < lo) return {1'b1, 32'(lo & mask)};
        end
        return {1'b0, 32'(t & mask)};
    endfunction

    function automatic string tag_of(input bit sg, input bit ac, input bit sb, input bit st);
        if (!ac) return sg ? "R2" : "R1";
        if (!st) return sb ? "R4" : "R3";
        return sg ? "R5" : "R6";
    endfunction

    task automatic check(input string tag, input logic [32:0] act, input logic [32:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual ovf=%0b res=%h expected ovf=%0b res=%h",
                     tag, act[32], act[31:0], exp[32], exp[31:0]);
        end
    endtask

    task automatic summary;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Directed operation on the 16-bit instance: drive one cycle, check, then check the hold.
    task automatic dir(input string tag, input logic [15:0] a, input logic [15:0] b,
                       input logic [31:0] acc, input bit sg, input bit ac, input bit sb,
                       input bit st);
        logic [32:0] e;
        e = model(DOW, longint'(a), longint'(b), longint'(acc), sg, ac, sb, st);
        @(negedge clk);
        d_iv = 1; d_a = a; d_b = b; d_acc = acc; d_sg = sg; d_ac = ac; d_sb = sb; d_st = st;
        @(negedge clk);
        d_iv = 0; d_a = ~a; d_acc = ~acc; d_sb = ~sb; d_st = ~st;
        check({tag, " R7"}, {d_ovf, d_res}, e);
        check("R8 valid", {32'd0, d_ov}, 33'd1);
        @(negedge clk);
        check("R9 hold", {d_ovf, d_res}, e);
        check("R8 idle", {32'd0, d_ov}, 33'd0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
        end
    end

    initial begin : main
        logic [32:0] pend, last;
        bit pend_v, have;
        int n;
        pend = '0; last = '0; pend_v = 0; have = 0; n = 0;

        // R10: reset state, with inputs active during reset
        @(negedge clk); s_iv = 1; d_iv = 1; s_a = '1; s_b = '1;
        d_a = '1; d_b = '1; d_ac = 1;
        repeat (2) @(negedge clk);
        check("R10 small", {s_ovf, s_res, s_ov} == '0 ? 33'd0 : 33'd1, 33'd0);
        check("R10 default", {d_ovf, d_res}, 33'd0);
        check("R10 valid", {32'd0, d_ov}, 33'd0);
        s_iv = 0; d_iv = 0; d_ac = 0;
        rst = 0;

        // Sweep on the 4-bit instance: all operand pairs, edge accumulators, all modes.
        for (int ai = 0; ai < 7; ai++) begin
            for (int m = 0; m < 16; m++) begin
                for (int x = 0; x < 256; x++) begin
                    logic [7:0] accv;
                    bit bubble;
                    case (ai)
                        0: accv = 8'h00; 1: accv = 8'h01; 2: accv = 8'h7F;
                        3: accv = 8'h80; 4: accv = 8'hFF; 5: accv = 8'h40;
                        default: accv = 8'hC3;
                    endcase
                    @(negedge clk);
                    if (have) begin
                        if (pend_v) begin
                            check({tag_of(s_sg, s_ac, s_sb, s_st), " R7 sweep"},
                                  {s_ovf, 24'd0, s_res}, pend);
                            check("R8 sweep valid", {32'd0, s_ov}, 33'd1);
                            last = pend;
                        end else begin
                            check("R9 sweep hold", {s_ovf, 24'd0, s_res}, last);
                            check("R8 sweep idle", {32'd0, s_ov}, 33'd0);
                        end
                    end
                    bubble = (n % 13) == 12;
                    n++;
                    s_iv = !bubble;
                    s_a = 4'(x); s_b = 4'(x >> 4); s_acc = accv;
                    s_sg = m[0]; s_ac = m[1]; s_sb = m[2]; s_st = m[3];
                    pend = model(SOW, longint'(s_a), longint'(s_b), longint'(s_acc),
                                 s_sg, s_ac, s_sb, s_st);
                    pend_v = !bubble;
                    have = 1;
                end
            end
        end
        @(negedge clk);
        s_iv = 0;

        // Directed 16-bit cases
        dir("R1", 16'hFFFF, 16'hFFFF, 32'h0, 0, 0, 0, 0);           // FFFE0001
        dir("R2", 16'h8000, 16'h8000, 32'h1234, 1, 0, 1, 1);        // 40000000, ovf 0
        dir("R2", 16'hFFFF, 16'h0002, 32'h0, 1, 0, 0, 0);           // FFFFFFFE
        dir("R3", 16'h0001, 16'h0001, 32'h7FFFFFFF, 1, 1, 0, 0);    // wraps to 80000000
        dir("R4", 16'h0001, 16'h0001, 32'h80000000, 1, 1, 1, 0);    // wraps to 7FFFFFFF
        dir("R5", 16'h0001, 16'h0001, 32'h7FFFFFFF, 1, 1, 0, 1);    // 7FFFFFFF ovf
        dir("R5", 16'h0001, 16'h0001, 32'h80000000, 1, 1, 1, 1);    // 80000000 ovf
        dir("R5", 16'h8000, 16'h8000, 32'h3FFFFFFF, 1, 1, 0, 1);    // 7FFFFFFF exact, ovf 0
        dir("R6", 16'h0010, 16'h0010, 32'hFFFFFFF0, 0, 1, 0, 1);    // FFFFFFFF ovf
        dir("R6", 16'h0003, 16'h0002, 32'h00000005, 0, 1, 1, 1);    // 0 ovf
        dir("R6", 16'h0001, 16'h0005, 32'h00000005, 0, 1, 1, 1);    // 0 exact, ovf 0
        dir("R6", 16'hFFFF, 16'hFFFF, 32'h80000000, 0, 1, 0, 0);    // wrap, ovf 0

        done = 1;
        summary();
    end
endmodule